// File: doc/BRIEF.md
# Chunked NAND Page Layout Remapper

A NAND page that is larger than the controller's per-chunk staging space is stored on the flash as a run of chunks. Each chunk is a 2048-byte data region, a 32-byte spare region and an ECC region, in that order. Software wants a different picture of the same page: every data byte first, in chunk order, and then the out-of-band area. This block converts between the two pictures. When a page is read, a byte stream arrives from the flash side in physical order, and the block delivers 64-bit words to the host in logical order. When a page is programmed, the block takes 64-bit host words in logical order and emits flash bytes in physical order.

There are two layouts. In normal mode each chunk on the flash stream carries only its data and spare bytes, because the ECC engine adds and strips the code bytes on its own. The host tail is then all spare regions back to back. In raw-OOB mode ECC checking is bypassed. The flash stream then also carries each chunk's ECC bytes, and the host tail holds one spare+ECC pair per chunk. The ECC length follows the selected code: 30 bytes per chunk for BCH, or 6 bytes per 512 data bytes (24 per chunk) for Hamming. A raw BCH pair is padded to 64 bytes so that every pair starts on a word boundary.

The spare area sits between data regions, so the block always moves the whole page through its internal page store and never the out-of-band area alone. One consequence is that the manufacturer's bad-block marker position falls inside a data region of the logical buffer.

Top module: `nand_page_remap`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the four stream handshake outputs (flashInReady, flashOutValid, hostOutValid, hostInReady), done and err are all low.
- R2: A normal read with cmdPageSize=1 works as follows. The flash stream carries, per chunk, 2048 data bytes then 32 spare bytes. The host receives the data of chunk 0, then the data of chunk 1, then the spare of chunk 0, then the spare of chunk 1. Host byte n of the buffer sits in word n/8, lane n%8, and lane k occupies bits [8k+7:8k].
- R3: In raw-OOB BCH read (cmdRaw=1, cmdBch=1), each flash chunk is data, 32 spare and 30 ECC bytes. Each chunk's host pair is its 32 spare bytes, then its 30 ECC bytes, then 2 bytes of zero.
- R4: In raw-OOB Hamming read (cmdRaw=1, cmdBch=0), each flash chunk carries 24 ECC bytes (6 per 512 data bytes). Each host pair is 56 bytes with no padding.
- R5: cmdPageSize selects 1 chunk (0), 2 chunks (1) or 4 chunks (2 or 3). The host side transfers exactly the logical length divided by 8 words, and no valid word follows the last one.
- R6: A normal program (cmdProgram=1) takes host words in the R2 logical order. It emits each chunk's 2048 data bytes and then its 32 spare bytes on the flash output, chunk by chunk.
- R7: A raw-OOB program emits each chunk's data, spare and ECC bytes on the flash output. The 2 pad bytes of each BCH pair supplied by the host are discarded and never reach the flash.
- R8: In a normal read of a 2-chunk page, the flash byte at physical offset 4096 (the factory marker position) is delivered as logical data byte 4064.
- R9: done is high for exactly one cycle, in the cycle after the final handshake of the page. That is the last host word for a read, and the last flash byte for a program.
- R10: A cmdStart seen while a transfer is in progress raises err for exactly one cycle, in the next cycle. The command is otherwise ignored and the running transfer completes with unchanged content.
- R11: While an output valid is high and its ready is low, the valid stays high and the data stays stable.
- R12: A read never raises hostInReady or flashOutValid, and a program never raises flashInReady or hostOutValid. The two input readies are never high together, and the two output valids are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | One-cycle command strobe |
| cmdProgram | input | 1 | 1: program (host to flash), 0: read (flash to host) |
| cmdRaw | input | 1 | 1: raw-OOB layout, 0: normal layout |
| cmdBch | input | 1 | 1: BCH ECC length, 0: Hamming ECC length |
| cmdPageSize | input | 2 | Chunk count select: 0→1, 1→2, 2/3→4 |
| flashInValid | input | 1 | Flash read byte valid |
| flashInData | input | 8 | Flash read byte |
| flashInReady | output | 1 | Block accepts a flash read byte |
| flashOutValid | output | 1 | Program byte valid toward flash |
| flashOutData | output | 8 | Program byte toward flash |
| flashOutReady | input | 1 | Flash side accepts program byte |
| hostOutValid | output | 1 | Host read word valid |
| hostOutData | output | 64 | Host read word |
| hostOutReady | input | 1 | Host accepts read word |
| hostInValid | input | 1 | Host program word valid |
| hostInData | input | 64 | Host program word |
| hostInReady | output | 1 | Block accepts a host program word |
| done | output | 1 | One-cycle end-of-page pulse |
| err | output | 1 | One-cycle pulse on a start while busy |

## Verification
A wrong chunk, region or offset counter does not show up at once. It appears as a misplaced byte in the host buffer or flash stream, either at the first region boundary (byte 2048 of a chunk), or only when the second chunk begins and its spare lands in the wrong tail slot. A wrong word count or end condition shows up right after the expected last word, either as a valid that stays high or as a missing done pulse, and a skipped or extra byte shifts every later byte of the page. The bad-block marker and pad lanes are single bytes, so they are compared individually: a pad mask on the wrong lane corrupts only the last word of each pair.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  localparam int CHUNK_DATA         = 2048;
  localparam int SPARE_BYTES        = 32;
  localparam int BCH_ECC            = 30;
  localparam int SECTOR_BYTES       = 512;
  localparam int HAM_ECC_PER_SECTOR = 6;
  localparam int MAX_CHUNKS         = 4;
  localparam int WORD_BYTES         = 8;

  localparam int HAM_ECC   = (CHUNK_DATA / SECTOR_BYTES) * HAM_ECC_PER_SECTOR;
  localparam int BCH_SLOT  = ((BCH_ECC + WORD_BYTES - 1) / WORD_BYTES) * WORD_BYTES;
  localparam int PAD_BYTES = BCH_SLOT - BCH_ECC;
  localparam int PAIR_MAX  = SPARE_BYTES + BCH_SLOT;
  localparam int MEM_BYTES = MAX_CHUNKS * (CHUNK_DATA + PAIR_MAX);
  localparam int MEM_WORDS = MEM_BYTES / WORD_BYTES;
  localparam int LANE_W    = $clog2(WORD_BYTES);
  localparam int WORD_W    = WORD_BYTES * 8;
  localparam int BA_W      = $clog2(MEM_BYTES);
  localparam int WA_W      = BA_W - LANE_W;
  localparam int OFF_W     = $clog2(CHUNK_DATA + 1);
  localparam int CH_W      = $clog2(MAX_CHUNKS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FLASH_IN, ST_HOST_OUT, ST_HOST_IN, ST_FLASH_OUT
  } state_t;

  typedef enum logic [1:0] { RG_DATA, RG_SPARE, RG_ECC } region_t;

  typedef struct packed {
    logic            byteWr;
    logic            wordWr;
    logic            padMask;
    logic [BA_W-1:0] byteAddr;
    logic [WA_W-1:0] wordAddr;
  } dpCtl_t;
endpackage

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
  import nrm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdProgram,
  input  logic       cmdRaw,
  input  logic       cmdBch,
  input  logic [1:0] cmdPageSize,
  input  logic       flashInValid,
  output logic       flashInReady,
  output logic       flashOutValid,
  input  logic       flashOutReady,
  output logic       hostOutValid,
  input  logic       hostOutReady,
  input  logic       hostInValid,
  output logic       hostInReady,
  output dpCtl_t     ctl,
  output logic       done,
  output logic       err
);
  state_t           state;
  region_t          region;
  logic             modeRaw, modeBch;
  logic [CH_W-1:0]  nChunks, chunk;
  logic [OFF_W-1:0] off;
  logic [WA_W-1:0]  wordIdx;

  logic [BA_W-1:0] totalData, tailPer, tailBase, regionLen, hostWords;
  logic regionEnd, chunkEnd, flashLast, wordLast, step;
  logic flashInFire, flashOutFire, hostOutFire, hostInFire;

  always_comb begin
    flashInReady  = (state == ST_FLASH_IN);
    hostOutValid  = (state == ST_HOST_OUT);
    hostInReady   = (state == ST_HOST_IN);
    flashOutValid = (state == ST_FLASH_OUT);
    flashInFire   = flashInValid & flashInReady;
    flashOutFire  = flashOutValid & flashOutReady;
    hostOutFire   = hostOutValid & hostOutReady;
    hostInFire    = hostInValid & hostInReady;
    step          = flashInFire | flashOutFire;

    totalData = BA_W'(nChunks) * BA_W'(CHUNK_DATA);
    if (!modeRaw)     tailPer = BA_W'(SPARE_BYTES);
    else if (modeBch) tailPer = BA_W'(SPARE_BYTES + BCH_SLOT);
    else              tailPer = BA_W'(SPARE_BYTES + HAM_ECC);
    tailBase  = totalData + BA_W'(chunk) * tailPer;
    hostWords = (totalData + BA_W'(nChunks) * tailPer) >> LANE_W;

    case (region)
      RG_DATA:  regionLen = BA_W'(CHUNK_DATA);
      RG_SPARE: regionLen = BA_W'(SPARE_BYTES);
      default:  regionLen = modeBch ? BA_W'(BCH_ECC) : BA_W'(HAM_ECC);
    endcase

    regionEnd = (BA_W'(off) == regionLen - BA_W'(1));
    chunkEnd  = regionEnd && ((region == RG_ECC) || (region == RG_SPARE && !modeRaw));
    flashLast = chunkEnd && (chunk == nChunks - CH_W'(1));
    wordLast  = (BA_W'(wordIdx) == hostWords - BA_W'(1));

    ctl.byteWr   = flashInFire;
    ctl.wordWr   = hostInFire;
    ctl.wordAddr = wordIdx;
    ctl.padMask  = modeRaw && modeBch && (BA_W'(wordIdx) >= (totalData >> LANE_W))
                   && (wordIdx[LANE_W-1:0] == {LANE_W{1'b1}});
    case (region)
      RG_DATA:  ctl.byteAddr = BA_W'(chunk) * BA_W'(CHUNK_DATA) + BA_W'(off);
      RG_SPARE: ctl.byteAddr = tailBase + BA_W'(off);
      default:  ctl.byteAddr = tailBase + BA_W'(SPARE_BYTES) + BA_W'(off);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      region  <= RG_DATA;
      modeRaw <= 1'b0;
      modeBch <= 1'b0;
      nChunks <= CH_W'(1);
      chunk   <= '0;
      off     <= '0;
      wordIdx <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= cmdStart && (state != ST_IDLE);

      if (step) begin
        if (regionEnd) begin
          off <= '0;
          if (chunkEnd) begin
            chunk  <= chunk + CH_W'(1);
            region <= RG_DATA;
          end else begin
            region <= (region == RG_DATA) ? RG_SPARE : RG_ECC;
          end
        end else begin
          off <= off + OFF_W'(1);
        end
      end

      case (state)
        ST_IDLE: if (cmdStart) begin
          modeRaw <= cmdRaw;
          modeBch <= cmdBch;
          case (cmdPageSize)
            2'd0:    nChunks <= CH_W'(1);
            2'd1:    nChunks <= CH_W'(2);
            default: nChunks <= CH_W'(4);
          endcase
          chunk   <= '0;
          region  <= RG_DATA;
          off     <= '0;
          wordIdx <= '0;
          state   <= cmdProgram ? ST_HOST_IN : ST_FLASH_IN;
        end
        ST_FLASH_IN: if (flashInFire && flashLast) state <= ST_HOST_OUT;
        ST_HOST_OUT: if (hostOutFire) begin
          if (wordLast) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            wordIdx <= wordIdx + WA_W'(1);
          end
        end
        ST_HOST_IN: if (hostInFire) begin
          if (wordLast) state <= ST_FLASH_OUT;
          else          wordIdx <= wordIdx + WA_W'(1);
        end
        ST_FLASH_OUT: if (flashOutFire && flashLast) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrm_datapath.sv
module nrm_datapath
  import nrm_pkg::*;
(
  input  logic              clk,
  input  dpCtl_t            ctl,
  input  logic [7:0]        flashInData,
  input  logic [WORD_W-1:0] hostInData,
  output logic [7:0]        flashOutData,
  output logic [WORD_W-1:0] hostOutData
);
  logic [WORD_W-1:0] pageMem [MEM_WORDS];
  logic [WORD_W-1:0] rdWord, byteWord;
  logic [WA_W-1:0]   byteWordIdx;
  logic [LANE_W-1:0] byteLane;

  assign byteWordIdx = ctl.byteAddr[BA_W-1:LANE_W];
  assign byteLane    = ctl.byteAddr[LANE_W-1:0];
  assign rdWord      = pageMem[ctl.wordAddr];
  assign byteWord    = pageMem[byteWordIdx];
  assign flashOutData = byteWord[{byteLane, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (ctl.wordWr)
      pageMem[ctl.wordAddr] <= hostInData;
    else if (ctl.byteWr)
      pageMem[byteWordIdx][{byteLane, 3'b000} +: 8] <= flashInData;
  end

  for (genvar lane = 0; lane < WORD_BYTES; lane++) begin : g_lane
    if (lane >= WORD_BYTES - PAD_BYTES) begin : g_pad
      assign hostOutData[lane*8 +: 8] = ctl.padMask ? 8'h00 : rdWord[lane*8 +: 8];
    end else begin : g_pass
      assign hostOutData[lane*8 +: 8] = rdWord[lane*8 +: 8];
    end
  end
endmodule

// File: rtl/nand_page_remap.sv
module nand_page_remap
  import nrm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdProgram,
  input  logic              cmdRaw,
  input  logic              cmdBch,
  input  logic [1:0]        cmdPageSize,
  input  logic              flashInValid,
  input  logic [7:0]        flashInData,
  output logic              flashInReady,
  output logic              flashOutValid,
  output logic [7:0]        flashOutData,
  input  logic              flashOutReady,
  output logic              hostOutValid,
  output logic [WORD_W-1:0] hostOutData,
  input  logic              hostOutReady,
  input  logic              hostInValid,
  input  logic [WORD_W-1:0] hostInData,
  output logic              hostInReady,
  output logic              done,
  output logic              err
);
  dpCtl_t ctl;

  nrm_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdProgram(cmdProgram),
    .cmdRaw(cmdRaw), .cmdBch(cmdBch), .cmdPageSize(cmdPageSize),
    .flashInValid(flashInValid), .flashInReady(flashInReady),
    .flashOutValid(flashOutValid), .flashOutReady(flashOutReady),
    .hostOutValid(hostOutValid), .hostOutReady(hostOutReady),
    .hostInValid(hostInValid), .hostInReady(hostInReady),
    .ctl(ctl), .done(done), .err(err)
  );

  nrm_datapath i_datapath (
    .clk(clk), .ctl(ctl), .flashInData(flashInData), .hostInData(hostInData),
    .flashOutData(flashOutData), .hostOutData(hostOutData)
  );
endmodule

// File: rtl/nrm_checker.sv
module nrm_checker
  import nrm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cmdStart,
  input logic              flashInReady,
  input logic              flashOutValid,
  input logic [7:0]        flashOutData,
  input logic              flashOutReady,
  input logic              hostOutValid,
  input logic [WORD_W-1:0] hostOutData,
  input logic              hostOutReady,
  input logic              hostInReady,
  input logic              done,
  input logic              err
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!flashInReady && !hostInReady && !hostOutValid && !flashOutValid && !done && !err)); // R1

  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(flashInReady && hostInReady) && !(hostOutValid && flashOutValid)); // R12

  AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    hostOutValid && !hostOutReady |=> hostOutValid && $stable(hostOutData)); // R11

  AST_FLASH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    flashOutValid && !flashOutReady |=> flashOutValid && $stable(flashOutData)); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past((hostOutValid && hostOutReady) || (flashOutValid && flashOutReady))); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> $past(cmdStart)); // R10

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    err && !$past(cmdStart, 1) |=> !err); // R10
endmodule

bind nand_page_remap nrm_checker i_nrm_checker (.*);

// File: tb/test_nand_page_remap.sv
module test_nand_page_remap;
  import nrm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 9;
  localparam int BUF        = 8448;
  // {seed[3:0], program, raw, bch, pageSize[1:0], expected count[13:0]}
  // expected count: host words for a read, flash bytes for a program
  localparam logic [22:0] VEC [NVEC] = '{
    {4'd1, 1'b0, 1'b0, 1'b0, 2'd0, 14'd260},
    {4'd2, 1'b0, 1'b0, 1'b0, 2'd1, 14'd520},
    {4'd3, 1'b0, 1'b0, 1'b0, 2'd2, 14'd1040},
    {4'd4, 1'b0, 1'b1, 1'b1, 2'd1, 14'd528},
    {4'd5, 1'b0, 1'b1, 1'b0, 2'd0, 14'd263},
    {4'd6, 1'b0, 1'b1, 1'b1, 2'd3, 14'd1056},
    {4'd7, 1'b1, 1'b0, 1'b0, 2'd1, 14'd4160},
    {4'd8, 1'b1, 1'b1, 1'b1, 2'd0, 14'd2110},
    {4'd9, 1'b1, 1'b1, 1'b0, 2'd2, 14'd8416}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, cmdProgram = 1'b0, cmdRaw = 1'b0, cmdBch = 1'b0;
  logic [1:0] cmdPageSize = 2'd0;
  logic flashInValid = 1'b0;
  logic [7:0] flashInData = 8'h00;
  logic flashInReady, flashOutValid, flashOutReady = 1'b0;
  logic [7:0] flashOutData;
  logic hostOutValid, hostOutReady = 1'b0;
  logic [63:0] hostOutData;
  logic hostInValid = 1'b0;
  logic [63:0] hostInData = 64'h0;
  logic hostInReady, done, err;

  nand_page_remap i_nand_page_remap (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cycles = 0;
  bit timedOut = 1'b0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) timedOut = 1'b1;
  end

  int applied = 0, miscomp = 0;
  int physLen, logLen;
  logic [7:0] phys [BUF];
  logic [7:0] logi [BUF];
  logic [7:0] got  [BUF];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    applied++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Physical and logical images of one page built from the layout rules.
  task automatic buildPage(input bit raw, input bit bch, input int nch,
                           input int seed, input bit prog);
    int p = 0;
    int eccLen = bch ? 30 : 24;
    int pair = raw ? (bch ? 64 : 56) : 32;
    int total = nch * 2048;
    for (int c = 0; c < nch; c++) begin
      int tb = total + c * pair;
      for (int d = 0; d < 2048; d++) begin
        phys[p] = 8'((p * 7) + (p >> 8) + seed * 29);
        logi[c * 2048 + d] = phys[p];
        p++;
      end
      for (int s = 0; s < 32; s++) begin
        phys[p] = 8'((p * 7) + (p >> 8) + seed * 29);
        logi[tb + s] = phys[p];
        p++;
      end
      if (raw) begin
        for (int e = 0; e < eccLen; e++) begin
          phys[p] = 8'((p * 7) + (p >> 8) + seed * 29);
          logi[tb + 32 + e] = phys[p];
          p++;
        end
        for (int e = eccLen; e < pair - 32; e++) logi[tb + 32 + e] = prog ? 8'hEE : 8'h00;
      end
    end
    physLen = p;
    logLen  = total + nch * pair;
  endtask

  task automatic startCmd(input bit prog, input bit raw, input bit bch, input logic [1:0] ps);
    @(negedge clk);
    cmdStart = 1'b1; cmdProgram = prog; cmdRaw = raw; cmdBch = bch; cmdPageSize = ps;
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  task automatic feedFlash(input int from, input int upto);
    int i = from;
    while (i < upto && !timedOut) begin
      @(negedge clk);
      flashInValid = 1'b1;
      flashInData  = phys[i];
      if (flashInReady) i++;
    end
    @(negedge clk);
    flashInValid = 1'b0;
  endtask

  task automatic collectHost(input int nw, output bit holdOk);
    int j = 0;
    bit pend = 1'b0;
    logic [63:0] pd = '0;
    holdOk = 1'b1;
    while (j < nw && !timedOut) begin
      @(negedge clk);
      if (pend && (!hostOutValid || hostOutData != pd)) holdOk = 1'b0;
      pend = 1'b0;
      hostOutReady = ((cycles % 7) != 3);
      if (hostOutValid) begin
        if (hostOutReady) begin
          for (int k = 0; k < 8; k++) got[j * 8 + k] = hostOutData[k * 8 +: 8];
          j++;
        end else begin
          pend = 1'b1;
          pd = hostOutData;
        end
      end
    end
  endtask

  task automatic sendHost(input int nw);
    int j = 0;
    while (j < nw && !timedOut) begin
      @(negedge clk);
      hostInValid = ((cycles % 5) != 2);
      for (int k = 0; k < 8; k++) hostInData[k * 8 +: 8] = logi[j * 8 + k];
      if (hostInValid && hostInReady) j++;
    end
    @(negedge clk);
    hostInValid = 1'b0;
  endtask

  task automatic collectFlash(input int nb, output bit holdOk);
    int j = 0;
    bit pend = 1'b0;
    logic [7:0] pd = '0;
    holdOk = 1'b1;
    while (j < nb && !timedOut) begin
      @(negedge clk);
      if (pend && (!flashOutValid || flashOutData != pd)) holdOk = 1'b0;
      pend = 1'b0;
      flashOutReady = ((cycles % 5) != 1);
      if (flashOutValid) begin
        if (flashOutReady) begin
          got[j] = flashOutData;
          j++;
        end else begin
          pend = 1'b1;
          pd = flashOutData;
        end
      end
    end
  endtask

  function automatic int firstMismatch(input int n, input bit hostSide);
    for (int i = 0; i < n; i++) begin
      if (hostSide && got[i] !== logi[i]) return i;
      if (!hostSide && got[i] !== phys[i]) return i;
    end
    return -1;
  endfunction

  initial begin
    bit hold;
    int mm;
    repeat (3) @(negedge clk);
    check(!flashInReady && !hostInReady && !hostOutValid && !flashOutValid && !done && !err,
          "R1", "outputs during reset",
          {flashInReady, hostInReady, hostOutValid, flashOutValid, done, err}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!flashInReady && !hostInReady && !hostOutValid && !flashOutValid && !done && !err,
          "R1", "outputs after reset",
          {flashInReady, hostInReady, hostOutValid, flashOutValid, done, err}, 0);

    for (int v = 0; v < NVEC && !timedOut; v++) begin
      logic [3:0]  seed = VEC[v][22:19];
      logic        prog = VEC[v][18];
      logic        raw  = VEC[v][17];
      logic        bch  = VEC[v][16];
      logic [1:0]  ps   = VEC[v][15:14];
      int          cnt  = int'(VEC[v][13:0]);
      int          nch  = (ps == 2'd0) ? 1 : (ps == 2'd1) ? 2 : 4;
      string       req  = prog ? (raw ? "R7" : "R6") : (raw ? (bch ? "R3" : "R4") : "R2");
      buildPage(raw, bch, nch, int'(seed), prog);
      startCmd(prog, raw, bch, ps);
      if (!prog) begin
        feedFlash(0, physLen);
        collectHost(cnt, hold);
        @(negedge clk);
        check(done === 1'b1, "R9", "done after last host word", done, 1);
        check(hostOutValid === 1'b0, "R5", "host valid after last word", hostOutValid, 0);
        hostOutReady = 1'b0;
        mm = firstMismatch(cnt * 8, 1'b1);
        check(mm < 0, req, "host buffer content", (mm < 0) ? 0 : got[mm], (mm < 0) ? 0 : logi[mm]);
        if (!raw && nch == 2)
          check(got[4064] === phys[4096], "R8", "marker byte at logical 4064", got[4064], phys[4096]);
      end else begin
        sendHost(logLen / 8);
        collectFlash(cnt, hold);
        @(negedge clk);
        check(done === 1'b1, "R9", "done after last flash byte", done, 1);
        check(flashOutValid === 1'b0, "R5", "flash valid after last byte", flashOutValid, 0);
        flashOutReady = 1'b0;
        mm = firstMismatch(cnt, 1'b0);
        check(mm < 0, req, "flash stream content", (mm < 0) ? 0 : got[mm], (mm < 0) ? 0 : phys[mm]);
      end
      check(hold, "R11", "output held under back-pressure", hold, 1);
      @(negedge clk);
      check(done === 1'b0, "R9", "done lasts one cycle", done, 0);
    end

    // R10: start while a normal 2 KiB read is in progress
    buildPage(1'b0, 1'b0, 1, 11, 1'b0);
    startCmd(1'b0, 1'b0, 1'b0, 2'd0);
    feedFlash(0, 100);
    @(negedge clk);
    cmdStart = 1'b1; cmdProgram = 1'b1; cmdRaw = 1'b1; cmdBch = 1'b1; cmdPageSize = 2'd2;
    @(negedge clk);
    cmdStart = 1'b0; cmdProgram = 1'b0; cmdRaw = 1'b0; cmdBch = 1'b0; cmdPageSize = 2'd0;
    check(err === 1'b1, "R10", "err after busy start", err, 1);
    check(flashInReady === 1'b1 && hostInReady === 1'b0, "R12", "direction kept after busy start",
          {flashInReady, hostInReady}, 2'b10);
    @(negedge clk);
    check(err === 1'b0, "R10", "err lasts one cycle", err, 0);
    feedFlash(100, physLen);
    collectHost(260, hold);
    @(negedge clk);
    check(done === 1'b1, "R10", "interrupted page completes", done, 1);
    hostOutReady = 1'b0;
    mm = firstMismatch(2080, 1'b1);
    check(mm < 0, "R10", "content unaffected by busy start",
          (mm < 0) ? 0 : got[mm], (mm < 0) ? 0 : logi[mm]);

    if (timedOut) begin
      applied++;
      miscomp++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end
endmodule